// File: doc/BRIEF.md
# Neighborhood Expanding Scratchpad Page Allocator

This block places the pages of one application that is entering a tiled many-core system into the scratchpad slots spread over a two-dimensional mesh of tiles. Page records arrive one at a time, already sorted by descending access count. For each record the allocator first looks at the scratchpad on the application's home tile. If no slot there qualifies, it widens the search ring by ring, visiting every tile at hop distance 0, then 1, then 2, and so on. A slot qualifies if it is empty, or if swapping out its resident page lowers the total access latency under a per-hop cost model. Pages of applications that are already running are never moved to another scratchpad. A page that loses its slot is sent off-chip.

A record is accepted only in IDLE or DRAIN. In IDLE an accepted record moves the machine to SCAN, which evaluates all slots of one tile per cycle. From SCAN, a hit on an occupied slot goes to EVICT, which reports the victim, and then to PLACE. A hit on a free slot goes straight to PLACE, which writes the slot table and returns to IDLE. If the ring at the radius threshold is finished without a hit, SCAN goes to SPILL, which reports the page as off-chip. SPILL then returns to IDLE if that record was the application's last, and otherwise goes to DRAIN. In DRAIN every further record of the application is accepted and sent through SPILL until the last one arrives. A lookup port reads back any slot of the table.

Top module: `nbr_page_alloc`

## Requirements
- R1: After reset every slot reads as empty on the lookup port, `rec_ready` is high and `ev_valid` is low.
- R2: A page is tried first against the home tile's scratchpad, and a free slot there is taken at the lowest slot index.
- R3: Failing that, tiles are searched in rings of increasing Manhattan hop distance from the home tile. Within a ring, tiles are visited in increasing index, where index = y*MESH_X + x. The first qualifying slot in that order is taken.
- R4: An occupied slot qualifies only if new_count*(OFF_COST - c_new) is strictly greater than old_count*(OFF_COST - c_old). Here c is 1 + 3*hops, with hops measured from each page's own home tile to the candidate tile, and OFF_COST defaults to 90.
- R5: Event kind encoding is 0 = place, 1 = evict, 2 = off-chip. A replacement reports the victim (its app, page, tile and slot) with kind 1, and in the next cycle reports the new page placed into the same tile and slot with kind 0.
- R6: A slot changes only when the entering page is written into it. An evicted page goes off-chip and is never moved to another slot, and all other slots keep their contents.
- R7: If the ring at distance RADIUS_MAX (default 2) completes without a hit, the pending page is reported off-chip (kind 2). Every later record of the application, up to and including the one with `rec_last` set, is also reported off-chip. After that a new application is handled normally.
- R8: `rec_ready` is high only while the allocator waits for a record, so it is low during the search. At most one event is reported per cycle, and never in a cycle where `rec_ready` is high.
- R9: The lookup port returns the occupancy flag, owning application and page number held in the selected tile and slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rec_valid | input | 1 | Page record offered |
| rec_ready | output | 1 | Allocator accepts a record this cycle |
| rec_app | input | APP_W | Application identifier |
| rec_home | input | TILE_W | Home tile index of the application |
| rec_page | input | PAGE_W | Virtual page number |
| rec_count | input | CNT_W | Access count of the page |
| rec_last | input | 1 | Final page of the application |
| ev_valid | output | 1 | Event reported this cycle |
| ev_kind | output | 2 | 0 place, 1 evict, 2 off-chip |
| ev_app | output | APP_W | Application of the page concerned |
| ev_page | output | PAGE_W | Page concerned |
| ev_tile | output | TILE_W | Tile of the slot (place and evict) |
| ev_slot | output | SLOT_W | Slot within the tile (place and evict) |
| lk_tile | input | TILE_W | Lookup tile |
| lk_slot | input | SLOT_W | Lookup slot |
| lk_busy | output | 1 | Lookup slot occupied |
| lk_app | output | APP_W | Owner of the looked-up slot |
| lk_page | output | PAGE_W | Page in the looked-up slot |

## Verification
The hardest case to reach is the radius threshold. To hit it, every slot within RADIUS_MAX hops of the home tile must hold a page whose weighted benefit beats the newcomer's. The stimulus fills all twelve such slots around a corner tile with a single application's pages in descending count order, then offers two low-count pages, so the first fails and the second must be drained off-chip. A second hard case is a replacement decided by hop weighting and not by raw count. Here a page with a lower count than a resident placed one hop away from its own home wins by a one-unit margin, and a page one count lower than that loses.

// File: rtl/nbr_alloc_pkg.sv
package nbr_alloc_pkg;

    typedef enum logic [1:0] {
        EV_PLACE   = 2'd0,
        EV_EVICT   = 2'd1,
        EV_OFFCHIP = 2'd2
    } ev_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SCAN  = 3'd1,
        ST_EVICT = 3'd2,
        ST_PLACE = 3'd3,
        ST_SPILL = 3'd4,
        ST_DRAIN = 3'd5
    } alloc_state_e;

endpackage

// File: rtl/nbr_hop_metric.sv
// Manhattan hop distance between two tile indices of a row-major mesh.
module nbr_hop_metric #(
    parameter int MESH_X = 4,
    parameter int TILE_W = 4,
    parameter int HOP_W  = 3
) (
    input  logic [TILE_W-1:0] tile_a,
    input  logic [TILE_W-1:0] tile_b,
    output logic [HOP_W-1:0]  hops
);
    localparam logic [TILE_W-1:0] ROW_LEN = TILE_W'(MESH_X);

    logic [TILE_W-1:0] ax, ay, bx, by, dx, dy;

    always_comb begin
        ax   = tile_a % ROW_LEN;
        ay   = tile_a / ROW_LEN;
        bx   = tile_b % ROW_LEN;
        by   = tile_b / ROW_LEN;
        dx   = (ax >= bx) ? (ax - bx) : (bx - ax);
        dy   = (ay >= by) ? (ay - by) : (by - ay);
        hops = HOP_W'(dx) + HOP_W'(dy);
    end
endmodule

// File: rtl/nbr_gain.sv
// Latency saved by holding a page on-chip at a given hop distance.
module nbr_gain #(
    parameter int CNT_W     = 16,
    parameter int HOP_W     = 3,
    parameter int COST_W    = 16,
    parameter int OFF_COST  = 90,
    parameter int BASE_COST = 1,
    parameter int HOP_COST  = 3,
    localparam int GAIN_W   = CNT_W + COST_W
) (
    input  logic [HOP_W-1:0]  hops,
    input  logic [CNT_W-1:0]  count,
    output logic [GAIN_W-1:0] gain
);
    logic [COST_W-1:0] near_cost;
    logic [COST_W-1:0] margin;

    always_comb begin
        near_cost = COST_W'(BASE_COST) + COST_W'(HOP_COST) * COST_W'(hops);
        margin    = (near_cost < COST_W'(OFF_COST)) ? (COST_W'(OFF_COST) - near_cost) : '0;
        gain      = GAIN_W'(count) * GAIN_W'(margin);
    end
endmodule

// File: rtl/nbr_slot_store.sv
// Slot occupancy and owner table: one write port, one whole-tile read port, one lookup port.
module nbr_slot_store #(
    parameter int TILES  = 16,
    parameter int SLOTS  = 2,
    parameter int TILE_W = 4,
    parameter int SLOT_W = 1,
    parameter int APP_W  = 4,
    parameter int PAGE_W = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [TILE_W-1:0] wr_tile,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [APP_W-1:0]  wr_app,
    input  logic [PAGE_W-1:0] wr_page,
    input  logic [TILE_W-1:0] wr_home,
    input  logic [CNT_W-1:0]  wr_cnt,
    input  logic [TILE_W-1:0] rd_tile,
    output logic [SLOTS-1:0]  rd_busy,
    output logic [APP_W-1:0]  rd_app  [SLOTS],
    output logic [PAGE_W-1:0] rd_page [SLOTS],
    output logic [TILE_W-1:0] rd_home [SLOTS],
    output logic [CNT_W-1:0]  rd_cnt  [SLOTS],
    input  logic [TILE_W-1:0] lk_tile,
    input  logic [SLOT_W-1:0] lk_slot,
    output logic              lk_busy,
    output logic [APP_W-1:0]  lk_app,
    output logic [PAGE_W-1:0] lk_page
);
    logic              busy_q [TILES][SLOTS];
    logic [APP_W-1:0]  app_q  [TILES][SLOTS];
    logic [PAGE_W-1:0] page_q [TILES][SLOTS];
    logic [TILE_W-1:0] home_q [TILES][SLOTS];
    logic [CNT_W-1:0]  cnt_q  [TILES][SLOTS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int t = 0; t < TILES; t++) begin
                for (int s = 0; s < SLOTS; s++) begin
                    busy_q[t][s] <= 1'b0;
                end
            end
        end else if (wr_en) begin
            busy_q[wr_tile][wr_slot] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            app_q[wr_tile][wr_slot]  <= wr_app;
            page_q[wr_tile][wr_slot] <= wr_page;
            home_q[wr_tile][wr_slot] <= wr_home;
            cnt_q[wr_tile][wr_slot]  <= wr_cnt;
        end
    end

    always_comb begin
        for (int s = 0; s < SLOTS; s++) begin
            rd_busy[s] = busy_q[rd_tile][s];
            rd_app[s]  = app_q[rd_tile][s];
            rd_page[s] = page_q[rd_tile][s];
            rd_home[s] = home_q[rd_tile][s];
            rd_cnt[s]  = cnt_q[rd_tile][s];
        end
        lk_busy = busy_q[lk_tile][lk_slot];
        lk_app  = app_q[lk_tile][lk_slot];
        lk_page = page_q[lk_tile][lk_slot];
    end
endmodule

// File: rtl/nbr_tile_judge.sv
// Evaluates every slot of the scanned tile in parallel and picks the lowest qualifying one.
module nbr_tile_judge #(
    parameter int MESH_X    = 4,
    parameter int SLOTS     = 2,
    parameter int TILE_W    = 4,
    parameter int SLOT_W    = 1,
    parameter int HOP_W     = 3,
    parameter int CNT_W     = 16,
    parameter int COST_W    = 16,
    parameter int OFF_COST  = 90,
    parameter int BASE_COST = 1,
    parameter int HOP_COST  = 3,
    localparam int GAIN_W   = CNT_W + COST_W
) (
    input  logic [TILE_W-1:0] scan_tile,
    input  logic [SLOTS-1:0]  slot_busy,
    input  logic [TILE_W-1:0] slot_home [SLOTS],
    input  logic [CNT_W-1:0]  slot_cnt  [SLOTS],
    input  logic [GAIN_W-1:0] new_gain,
    output logic              hit,
    output logic [SLOT_W-1:0] hit_slot,
    output logic              hit_busy
);
    logic [SLOTS-1:0] qual;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic [HOP_W-1:0]  old_hops;
        logic [GAIN_W-1:0] old_gain;

        nbr_hop_metric #(
            .MESH_X (MESH_X),
            .TILE_W (TILE_W),
            .HOP_W  (HOP_W)
        ) u_hops (
            .tile_a (slot_home[s]),
            .tile_b (scan_tile),
            .hops   (old_hops)
        );

        nbr_gain #(
            .CNT_W     (CNT_W),
            .HOP_W     (HOP_W),
            .COST_W    (COST_W),
            .OFF_COST  (OFF_COST),
            .BASE_COST (BASE_COST),
            .HOP_COST  (HOP_COST)
        ) u_gain (
            .hops  (old_hops),
            .count (slot_cnt[s]),
            .gain  (old_gain)
        );

        assign qual[s] = !slot_busy[s] || (new_gain > old_gain);
    end

    always_comb begin
        hit_slot = '0;
        for (int s = SLOTS - 1; s >= 0; s--) begin
            if (qual[s]) begin
                hit_slot = SLOT_W'(s);
            end
        end
        hit      = |qual;
        hit_busy = slot_busy[hit_slot];
    end
endmodule

// File: rtl/nbr_page_alloc.sv
// Ring-by-ring page allocator for one entering application.
module nbr_page_alloc
    import nbr_alloc_pkg::*;
#(
    parameter int MESH_X     = 4,
    parameter int MESH_Y     = 4,
    parameter int SLOTS      = 2,
    parameter int APP_W      = 4,
    parameter int PAGE_W     = 8,
    parameter int CNT_W      = 16,
    parameter int COST_W     = 16,
    parameter int OFF_COST   = 90,
    parameter int BASE_COST  = 1,
    parameter int HOP_COST   = 3,
    parameter int RADIUS_MAX = 2,
    localparam int TILES     = MESH_X * MESH_Y,
    localparam int TILE_W    = (TILES > 1) ? $clog2(TILES) : 1,
    localparam int SLOT_W    = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int HOP_W     = $clog2(MESH_X + MESH_Y),
    localparam int GAIN_W    = CNT_W + COST_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rec_valid,
    output logic              rec_ready,
    input  logic [APP_W-1:0]  rec_app,
    input  logic [TILE_W-1:0] rec_home,
    input  logic [PAGE_W-1:0] rec_page,
    input  logic [CNT_W-1:0]  rec_count,
    input  logic              rec_last,
    output logic              ev_valid,
    output logic [1:0]        ev_kind,
    output logic [APP_W-1:0]  ev_app,
    output logic [PAGE_W-1:0] ev_page,
    output logic [TILE_W-1:0] ev_tile,
    output logic [SLOT_W-1:0] ev_slot,
    input  logic [TILE_W-1:0] lk_tile,
    input  logic [SLOT_W-1:0] lk_slot,
    output logic              lk_busy,
    output logic [APP_W-1:0]  lk_app,
    output logic [PAGE_W-1:0] lk_page
);
    alloc_state_e state_q, state_d;

    // current record and search position
    logic [APP_W-1:0]  cur_app_q;
    logic [TILE_W-1:0] cur_home_q;
    logic [PAGE_W-1:0] cur_page_q;
    logic [CNT_W-1:0]  cur_cnt_q;
    logic              cur_last_q;
    logic [HOP_W-1:0]  ring_q;
    logic [TILE_W-1:0] scan_q;
    logic [SLOT_W-1:0] hit_slot_q;
    logic [APP_W-1:0]  vic_app_q;
    logic [PAGE_W-1:0] vic_page_q;

    // scanned tile view
    logic [SLOTS-1:0]  slot_busy;
    logic [APP_W-1:0]  slot_app  [SLOTS];
    logic [PAGE_W-1:0] slot_page [SLOTS];
    logic [TILE_W-1:0] slot_home [SLOTS];
    logic [CNT_W-1:0]  slot_cnt  [SLOTS];

    logic [HOP_W-1:0]  scan_hops;
    logic [GAIN_W-1:0] new_gain;
    logic              judge_hit;
    logic [SLOT_W-1:0] judge_slot;
    logic              judge_busy;

    logic rec_take;
    logic in_ring;
    logic take_slot;
    logic last_tile;
    logic last_ring;
    logic wr_en;

    nbr_hop_metric #(
        .MESH_X (MESH_X),
        .TILE_W (TILE_W),
        .HOP_W  (HOP_W)
    ) u_ring_dist (
        .tile_a (scan_q),
        .tile_b (cur_home_q),
        .hops   (scan_hops)
    );

    nbr_gain #(
        .CNT_W     (CNT_W),
        .HOP_W     (HOP_W),
        .COST_W    (COST_W),
        .OFF_COST  (OFF_COST),
        .BASE_COST (BASE_COST),
        .HOP_COST  (HOP_COST)
    ) u_new_gain (
        .hops  (ring_q),
        .count (cur_cnt_q),
        .gain  (new_gain)
    );

    nbr_slot_store #(
        .TILES  (TILES),
        .SLOTS  (SLOTS),
        .TILE_W (TILE_W),
        .SLOT_W (SLOT_W),
        .APP_W  (APP_W),
        .PAGE_W (PAGE_W),
        .CNT_W  (CNT_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_tile (scan_q),
        .wr_slot (hit_slot_q),
        .wr_app  (cur_app_q),
        .wr_page (cur_page_q),
        .wr_home (cur_home_q),
        .wr_cnt  (cur_cnt_q),
        .rd_tile (scan_q),
        .rd_busy (slot_busy),
        .rd_app  (slot_app),
        .rd_page (slot_page),
        .rd_home (slot_home),
        .rd_cnt  (slot_cnt),
        .lk_tile (lk_tile),
        .lk_slot (lk_slot),
        .lk_busy (lk_busy),
        .lk_app  (lk_app),
        .lk_page (lk_page)
    );

    nbr_tile_judge #(
        .MESH_X    (MESH_X),
        .SLOTS     (SLOTS),
        .TILE_W    (TILE_W),
        .SLOT_W    (SLOT_W),
        .HOP_W     (HOP_W),
        .CNT_W     (CNT_W),
        .COST_W    (COST_W),
        .OFF_COST  (OFF_COST),
        .BASE_COST (BASE_COST),
        .HOP_COST  (HOP_COST)
    ) u_judge (
        .scan_tile (scan_q),
        .slot_busy (slot_busy),
        .slot_home (slot_home),
        .slot_cnt  (slot_cnt),
        .new_gain  (new_gain),
        .hit       (judge_hit),
        .hit_slot  (judge_slot),
        .hit_busy  (judge_busy)
    );

    assign rec_take  = rec_valid && rec_ready;
    assign in_ring   = (scan_hops == ring_q);
    assign take_slot = (state_q == ST_SCAN) && in_ring && judge_hit;
    assign last_tile = (scan_q == TILE_W'(TILES - 1));
    assign last_ring = (ring_q == HOP_W'(RADIUS_MAX));
    assign wr_en     = (state_q == ST_PLACE);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (rec_valid) state_d = ST_SCAN;
            end
            ST_SCAN: begin
                if (take_slot) begin
                    state_d = judge_busy ? ST_EVICT : ST_PLACE;
                end else if (last_tile && last_ring) begin
                    state_d = ST_SPILL;
                end
            end
            ST_EVICT: state_d = ST_PLACE;
            ST_PLACE: state_d = ST_IDLE;
            ST_SPILL: state_d = cur_last_q ? ST_IDLE : ST_DRAIN;
            ST_DRAIN: begin
                if (rec_valid) state_d = ST_SPILL;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // record, search position and victim capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_app_q  <= '0;
            cur_home_q <= '0;
            cur_page_q <= '0;
            cur_cnt_q  <= '0;
            cur_last_q <= 1'b0;
            ring_q     <= '0;
            scan_q     <= '0;
            hit_slot_q <= '0;
            vic_app_q  <= '0;
            vic_page_q <= '0;
        end else begin
            if (rec_take) begin
                cur_app_q  <= rec_app;
                cur_home_q <= rec_home;
                cur_page_q <= rec_page;
                cur_cnt_q  <= rec_count;
                cur_last_q <= rec_last;
                ring_q     <= '0;
                scan_q     <= '0;
            end else if (state_q == ST_SCAN) begin
                if (take_slot) begin
                    hit_slot_q <= judge_slot;
                    vic_app_q  <= slot_app[judge_slot];
                    vic_page_q <= slot_page[judge_slot];
                end else if (last_tile) begin
                    scan_q <= '0;
                    if (!last_ring) ring_q <= ring_q + 1'b1;
                end else begin
                    scan_q <= scan_q + 1'b1;
                end
            end
        end
    end

    // outputs
    always_comb begin
        rec_ready = 1'b0;
        ev_valid  = 1'b0;
        ev_kind   = EV_PLACE;
        ev_app    = cur_app_q;
        ev_page   = cur_page_q;
        ev_tile   = scan_q;
        ev_slot   = hit_slot_q;
        unique case (state_q)
            ST_IDLE:  rec_ready = 1'b1;
            ST_SCAN:  ;
            ST_EVICT: begin
                ev_valid = 1'b1;
                ev_kind  = EV_EVICT;
                ev_app   = vic_app_q;
                ev_page  = vic_page_q;
            end
            ST_PLACE: ev_valid = 1'b1;
            ST_SPILL: begin
                ev_valid = 1'b1;
                ev_kind  = EV_OFFCHIP;
                ev_tile  = '0;
                ev_slot  = '0;
            end
            ST_DRAIN: rec_ready = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/nbr_page_alloc_chk.sv
module nbr_page_alloc_chk
    import nbr_alloc_pkg::*;
#(
    parameter int SLOTS  = 2,
    parameter int TILE_W = 4,
    parameter int SLOT_W = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rec_ready,
    input logic              ev_valid,
    input logic [1:0]        ev_kind,
    input logic [TILE_W-1:0] ev_tile,
    input logic [SLOT_W-1:0] ev_slot,
    input logic [SLOTS-1:0]  slot_busy
);
    logic is_evict, is_place;
    assign is_evict = ev_valid && (ev_kind == EV_EVICT);
    assign is_place = ev_valid && (ev_kind == EV_PLACE);

    AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        rec_ready |-> !ev_valid);  // R8

    AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid |-> (ev_kind != 2'd3));  // R5

    AST_EVICT_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        is_evict |=> (is_place && ev_tile == $past(ev_tile) && ev_slot == $past(ev_slot)));  // R5

    AST_EVICT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        is_evict |-> slot_busy[ev_slot]);  // R6

    AST_PLACE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        is_place |=> slot_busy[$past(ev_slot)]);  // R6

    AST_NO_SILENT_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (is_place && slot_busy[ev_slot]) |-> $past(is_evict));  // R4
endmodule

bind nbr_page_alloc nbr_page_alloc_chk #(
    .SLOTS  (SLOTS),
    .TILE_W (TILE_W),
    .SLOT_W (SLOT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rec_ready (rec_ready),
    .ev_valid  (ev_valid),
    .ev_kind   (ev_kind),
    .ev_tile   (ev_tile),
    .ev_slot   (ev_slot),
    .slot_busy (slot_busy)
);

// File: tb/nbr_page_alloc_tb.sv
`timescale 1ns/1ps
module nbr_page_alloc_tb;
    import nbr_alloc_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        rec_valid;
    logic        rec_ready;
    logic [3:0]  rec_app;
    logic [3:0]  rec_home;
    logic [7:0]  rec_page;
    logic [15:0] rec_count;
    logic        rec_last;
    logic        ev_valid;
    logic [1:0]  ev_kind;
    logic [3:0]  ev_app;
    logic [7:0]  ev_page;
    logic [3:0]  ev_tile;
    logic        ev_slot;
    logic [3:0]  lk_tile;
    logic        lk_slot;
    logic        lk_busy;
    logic [3:0]  lk_app;
    logic [7:0]  lk_page;

    int checks = 0;
    int errors = 0;

    typedef struct packed {
        logic [1:0] kind;
        logic [3:0] app;
        logic [7:0] page;
        logic [3:0] tile;
        logic       slot;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];

    always #10 clk = ~clk;

    nbr_page_alloc u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .rec_valid (rec_valid),
        .rec_ready (rec_ready),
        .rec_app   (rec_app),
        .rec_home  (rec_home),
        .rec_page  (rec_page),
        .rec_count (rec_count),
        .rec_last  (rec_last),
        .ev_valid  (ev_valid),
        .ev_kind   (ev_kind),
        .ev_app    (ev_app),
        .ev_page   (ev_page),
        .ev_tile   (ev_tile),
        .ev_slot   (ev_slot),
        .lk_tile   (lk_tile),
        .lk_slot   (lk_slot),
        .lk_busy   (lk_busy),
        .lk_app    (lk_app),
        .lk_page   (lk_page)
    );

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic expect_ev(input int kind, input int app, input int page, input int tile, input int slot, input string tag);
        exp_t e;
        e.kind = 2'(kind);
        e.app  = 4'(app);
        e.page = 8'(page);
        e.tile = 4'(tile);
        e.slot = 1'(slot);
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // monitor: compare each reported event against the scoreboard
    always @(negedge clk) begin
        if (rst_n && ev_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R8: unexpected event kind=%0d app=%0d page=%0d expected=none",
                         ev_kind, ev_app, ev_page);
            end else begin
                exp_t  e;
                string t;
                bit    ok;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                ok = (ev_kind == e.kind) && (ev_app == e.app) && (ev_page == e.page);
                if (e.kind != 2'd2) ok = ok && (ev_tile == e.tile) && (ev_slot == e.slot);
                if (!ok) begin
                    errors++;
                    $display("FAIL %s: actual kind=%0d app=%0d page=%0d tile=%0d slot=%0d expected kind=%0d app=%0d page=%0d tile=%0d slot=%0d",
                             t, ev_kind, ev_app, ev_page, ev_tile, ev_slot,
                             e.kind, e.app, e.page, e.tile, e.slot);
                end
            end
        end
    end

    task automatic do_reset();
        rst_n     = 1'b0;
        rec_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic send(input int app, input int home, input int page, input int cnt, input bit last);
        @(negedge clk);
        rec_valid = 1'b1;
        rec_app   = 4'(app);
        rec_home  = 4'(home);
        rec_page  = 8'(page);
        rec_count = 16'(cnt);
        rec_last  = last;
        while (!rec_ready) @(negedge clk);
        @(negedge clk);
        rec_valid = 1'b0;
    endtask

    task automatic drain(input string tag);
        int n = 0;
        while ((exp_q.size() != 0 || !rec_ready) && n < 2000) begin
            @(negedge clk);
            n++;
        end
        repeat (2) @(negedge clk);
        chk(exp_q.size() == 0, tag, "events still missing", exp_q.size(), 0);
    endtask

    task automatic look(input int tile, input int slot, input bit busy, input int app, input int page, input string tag);
        @(negedge clk);
        lk_tile = 4'(tile);
        lk_slot = 1'(slot);
        #1;
        chk(lk_busy == busy, tag, "lookup busy", lk_busy, busy);
        if (busy) begin
            chk(lk_app == 4'(app), tag, "lookup app", lk_app, app);
            chk(lk_page == 8'(page), tag, "lookup page", lk_page, page);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        lk_tile   = '0;
        lk_slot   = '0;
        rec_app   = '0;
        rec_home  = '0;
        rec_page  = '0;
        rec_count = '0;
        rec_last  = 1'b0;
        do_reset();

        // R1: reset state
        chk(rec_ready == 1'b1, "R1", "rec_ready after reset", rec_ready, 1);
        chk(ev_valid == 1'b0, "R1", "ev_valid after reset", ev_valid, 0);
        begin
            int busy_cnt = 0;
            for (int t = 0; t < 16; t++) begin
                for (int s = 0; s < 2; s++) begin
                    lk_tile = 4'(t);
                    lk_slot = 1'(s);
                    #1;
                    if (lk_busy) busy_cnt++;
                end
            end
            chk(busy_cnt == 0, "R1", "occupied slots after reset", busy_cnt, 0);
        end

        // S1: home tile 5 first, then ring 1 (tiles 1,4,6,9 -> tile 1 first)
        expect_ev(0, 1, 0, 5, 0, "R2");
        expect_ev(0, 1, 1, 5, 1, "R2");
        expect_ev(0, 1, 2, 1, 0, "R3");
        expect_ev(0, 1, 3, 1, 1, "R3");
        send(1, 5, 0, 100, 1'b0);
        chk(rec_ready == 1'b0, "R8", "rec_ready during search", rec_ready, 0);
        send(1, 5, 1, 90, 1'b0);
        send(1, 5, 2, 80, 1'b0);
        send(1, 5, 3, 70, 1'b1);
        drain("R3");

        // S2: app 2 home 1 displaces app1 page 2 (95*89 > 80*86), then ring 1 tile 0
        expect_ev(1, 1, 2, 1, 0, "R5");
        expect_ev(0, 2, 0, 1, 0, "R4");
        expect_ev(0, 2, 1, 0, 0, "R3");
        expect_ev(0, 2, 2, 0, 1, "R3");
        send(2, 1, 0, 95, 1'b0);
        send(2, 1, 1, 10, 1'b0);
        send(2, 1, 2, 5, 1'b1);
        drain("R5");
        look(1, 0, 1'b1, 2, 0, "R9");
        look(1, 1, 1'b1, 1, 3, "R6");
        look(5, 0, 1'b1, 1, 0, "R6");
        look(5, 1, 1'b1, 1, 1, "R6");

        // S3: fill all 12 slots within 2 hops of tile 0, then overflow and drain
        do_reset();
        begin
            int tiles[12] = '{0, 0, 1, 1, 4, 4, 2, 2, 5, 5, 8, 8};
            for (int i = 0; i < 12; i++) begin
                expect_ev(0, 3, i, tiles[i], i % 2, "R3");
            end
        end
        expect_ev(2, 3, 12, 0, 0, "R7");
        expect_ev(2, 3, 13, 0, 0, "R7");
        expect_ev(0, 5, 0, 15, 0, "R7");
        for (int i = 0; i < 12; i++) begin
            send(3, 0, i, 200 - i, 1'b0);
        end
        send(3, 0, 12, 50, 1'b0);
        send(3, 0, 13, 40, 1'b1);
        send(5, 15, 0, 7, 1'b1);
        drain("R7");
        look(3, 0, 1'b0, 0, 0, "R6");
        look(8, 1, 1'b1, 3, 11, "R9");
        look(0, 0, 1'b1, 3, 0, "R6");

        // S4: strict comparison and hop-weighted replacement
        do_reset();
        expect_ev(0, 1, 0, 0, 0, "R2");
        expect_ev(0, 1, 1, 0, 1, "R4");
        expect_ev(0, 2, 0, 1, 0, "R4");
        expect_ev(0, 4, 0, 1, 1, "R4");
        expect_ev(1, 2, 0, 1, 0, "R5");
        expect_ev(0, 3, 0, 1, 0, "R4");
        send(1, 0, 0, 30, 1'b0);
        send(1, 0, 1, 30, 1'b1);
        send(2, 0, 0, 30, 1'b1);
        send(4, 1, 0, 28, 1'b1);
        send(3, 1, 0, 29, 1'b1);
        drain("R4");
        look(1, 0, 1'b1, 3, 0, "R9");
        look(1, 1, 1'b1, 4, 0, "R6");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule